// File: doc/BRIEF.md
# Dual-Clock DDR Input Capture Register

This block turns a one-bit double-data-rate input into two single-rate outputs. Two clocks drive it: a primary clock and a secondary clock that nominally runs 180 degrees out of phase with the primary. The bit present at a primary rising edge goes to `rise_q`, and the bit present at a secondary rising edge goes to `fall_q`. A bit pair is the primary-edge bit followed by the next secondary-edge bit.

A compile-time parameter sets how the two outputs line up in time.

- **Opposite mode:** each output follows its own clock.
- **Same mode:** the secondary-edge bit passes through one more register on the primary clock, so both outputs move on primary edges. The two halves of a pair then appear one cycle apart.
- **Pipelined mode:** the primary-edge bit also gets a retiming register. Each full pair then appears together, one primary cycle later than in same mode.

An active-high clear and an active-high preset act on every register. A parameter makes them synchronous or asynchronous. A shared capture enable freezes all registers when it is low. Power-up values for each output path are set by parameter.

Top module: `ddr2clk_capture`

## Requirements
- R1: At power-up, before any clock edge changes a register, `rise_q` equals `RISE_INIT` and `fall_q` equals `FALL_INIT`.
- R2: With `MODE` = `ALIGN_OPPOSITE` (encoding 0), `rise_q` shows the bit sampled at the latest primary rising edge, and `fall_q` shows the bit sampled at the latest secondary rising edge.
- R3: With `MODE` = `ALIGN_SAME` (encoding 1), after primary edge k, `rise_q` carries the primary bit of pair k and `fall_q` carries the secondary bit of pair k-1. The `fall_q` value after the first enabled primary edge is undefined.
- R4: With `MODE` = `ALIGN_SAME_PIPE` (encoding 2), after primary edge k, `rise_q` and `fall_q` carry both bits of pair k-1 together.
- R5: A high `clear_in` drives every register to 0, and it overrides `preset_in` when both are high.
- R6: A high `preset_in` with `clear_in` low drives every register to 1.
- R7: With `ASYNC_CTRL` = 0, clear and preset act only at a rising edge of the clock that owns each register. An output fed by the primary clock does not change between primary edges.
- R8: With `ASYNC_CTRL` = 1, clear and preset change the outputs at once, without waiting for a clock edge.
- R9: While `cap_en` is low, every register holds its value on both clocks and ignores `ddr_in`. Clear and preset still take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri | input | 1 | Primary clock; its rising edge captures the first bit of a pair |
| clk_sec | input | 1 | Secondary clock, nominally the inverse of `clk_pri`; its rising edge captures the second bit |
| cap_en | input | 1 | Capture enable; low freezes all registers |
| ddr_in | input | 1 | Serial double-data-rate input |
| clear_in | input | 1 | Active-high clear to 0; has priority over preset |
| preset_in | input | 1 | Active-high preset to 1 |
| rise_q | output | 1 | First bit of each pair |
| fall_q | output | 1 | Second bit of each pair |

## Verification
The hardest behaviour to bring out at the ports is the difference between synchronous and asynchronous control. It shows only when clear rises strictly between two primary edges, while the outputs still hold a 1 left by an earlier preset. The bench presets all three instances, raises clear one nanosecond after a primary edge, and samples straight away. The asynchronous instance must already read 0, and the synchronous ones must still read 1 until the next primary edge. The skewed pairing of same mode is checked by feeding a fixed pair table and comparing each output against the pair index that mode should show.

// File: rtl/ddr2clk_pkg.sv
package ddr2clk_pkg;

    // Output alignment of the captured pair
    typedef enum logic [1:0] {
        ALIGN_OPPOSITE  = 2'd0,
        ALIGN_SAME      = 2'd1,
        ALIGN_SAME_PIPE = 2'd2
    } align_mode_e;

endpackage

// File: rtl/ddr2clk_bit_reg.sv
module ddr2clk_bit_reg #(
    parameter bit INIT_VAL   = 1'b0,
    parameter bit ASYNC_CTRL = 1'b0
) (
    input  logic clk,
    input  logic en,
    input  logic clear,
    input  logic preset,
    input  logic d,
    output logic q
);

    // Power-up content of the storage element
    logic state_q = INIT_VAL;

    generate
        if (ASYNC_CTRL) begin : g_async
            always_ff @(posedge clk or posedge clear or posedge preset) begin
                if (clear)       state_q <= 1'b0;
                else if (preset) state_q <= 1'b1;
                else if (en)     state_q <= d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (clear)       state_q <= 1'b0;
                else if (preset) state_q <= 1'b1;
                else if (en)     state_q <= d;
            end
        end
    endgenerate

    assign q = state_q;

endmodule

// File: rtl/ddr2clk_capture.sv
module ddr2clk_capture #(
    parameter ddr2clk_pkg::align_mode_e MODE = ddr2clk_pkg::ALIGN_OPPOSITE,
    parameter bit RISE_INIT  = 1'b0,
    parameter bit FALL_INIT  = 1'b0,
    parameter bit ASYNC_CTRL = 1'b0
) (
    input  logic clk_pri,
    input  logic clk_sec,
    input  logic cap_en,
    input  logic ddr_in,
    input  logic clear_in,
    input  logic preset_in,
    output logic rise_q,
    output logic fall_q
);

    logic rise_cap;
    logic fall_cap;

    // First bit of the pair, taken on the primary clock
    ddr2clk_bit_reg #(.INIT_VAL(RISE_INIT), .ASYNC_CTRL(ASYNC_CTRL)) u_rise_cap (
        .clk(clk_pri), .en(cap_en), .clear(clear_in), .preset(preset_in),
        .d(ddr_in), .q(rise_cap)
    );

    // Second bit of the pair, taken on the secondary clock
    ddr2clk_bit_reg #(.INIT_VAL(FALL_INIT), .ASYNC_CTRL(ASYNC_CTRL)) u_fall_cap (
        .clk(clk_sec), .en(cap_en), .clear(clear_in), .preset(preset_in),
        .d(ddr_in), .q(fall_cap)
    );

    generate
        if (MODE == ddr2clk_pkg::ALIGN_OPPOSITE) begin : g_opposite
            assign rise_q = rise_cap;
            assign fall_q = fall_cap;
        end else if (MODE == ddr2clk_pkg::ALIGN_SAME) begin : g_same
            // Move the secondary bit onto the primary clock
            ddr2clk_bit_reg #(.INIT_VAL(FALL_INIT), .ASYNC_CTRL(ASYNC_CTRL)) u_fall_rt (
                .clk(clk_pri), .en(cap_en), .clear(clear_in), .preset(preset_in),
                .d(fall_cap), .q(fall_q)
            );
            assign rise_q = rise_cap;
        end else begin : g_same_pipe
            // Delay the primary bit as well so both halves of a pair meet
            ddr2clk_bit_reg #(.INIT_VAL(RISE_INIT), .ASYNC_CTRL(ASYNC_CTRL)) u_rise_rt (
                .clk(clk_pri), .en(cap_en), .clear(clear_in), .preset(preset_in),
                .d(rise_cap), .q(rise_q)
            );
            ddr2clk_bit_reg #(.INIT_VAL(FALL_INIT), .ASYNC_CTRL(ASYNC_CTRL)) u_fall_rt (
                .clk(clk_pri), .en(cap_en), .clear(clear_in), .preset(preset_in),
                .d(fall_cap), .q(fall_q)
            );
        end
    endgenerate

endmodule

// File: rtl/ddr2clk_capture_chk.sv
module ddr2clk_capture_chk #(
    parameter ddr2clk_pkg::align_mode_e MODE = ddr2clk_pkg::ALIGN_OPPOSITE
) (
    input logic clk_pri,
    input logic clk_sec,
    input logic cap_en,
    input logic ddr_in,
    input logic clear_in,
    input logic preset_in,
    input logic rise_q,
    input logic fall_q
);

    // R5
    clear_zero_chk: assert property (@(posedge clk_pri) disable iff (preset_in)
        clear_in |=> !rise_q);

    // R6
    preset_one_chk: assert property (@(posedge clk_pri) disable iff (clear_in)
        preset_in |=> rise_q);

    // R9
    hold_rise_chk: assert property (@(posedge clk_pri) disable iff (clear_in || preset_in)
        !cap_en |=> $stable(rise_q));

    // R9
    hold_fall_chk: assert property (@(posedge clk_sec) disable iff (clear_in || preset_in)
        !cap_en |=> $stable(fall_q));

    generate
        if (MODE == ddr2clk_pkg::ALIGN_SAME_PIPE) begin : g_pipe
            // R4
            rise_lag_chk: assert property (@(posedge clk_pri) disable iff (clear_in || preset_in)
                ($past(cap_en, 1) && $past(cap_en, 2) &&
                 $past(!clear_in && !preset_in, 1) && $past(!clear_in && !preset_in, 2))
                |-> (rise_q == $past(ddr_in, 2)));
        end else begin : g_direct
            // R2
            rise_lag_chk: assert property (@(posedge clk_pri) disable iff (clear_in || preset_in)
                ($past(cap_en) && $past(!clear_in && !preset_in))
                |-> (rise_q == $past(ddr_in)));
        end
    endgenerate

endmodule

bind ddr2clk_capture ddr2clk_capture_chk #(.MODE(MODE)) u_chk (
    .clk_pri(clk_pri), .clk_sec(clk_sec), .cap_en(cap_en), .ddr_in(ddr_in),
    .clear_in(clear_in), .preset_in(preset_in), .rise_q(rise_q), .fall_q(fall_q)
);

// File: tb/ddr2clk_capture_tb.sv
module ddr2clk_capture_tb;

    localparam int NPAIR = 8;
    // [1] = primary-edge bit, [0] = secondary-edge bit
    localparam logic [1:0] PAIRS [0:NPAIR-1] = '{
        2'b10, 2'b01, 2'b11, 2'b00, 2'b10, 2'b01, 2'b00, 2'b11
    };

    logic clk_pri = 1'b0;
    logic clk_sec;
    logic cap_en = 1'b0;
    logic ddr_in = 1'b0;
    logic clear_in = 1'b0;
    logic preset_in = 1'b0;
    logic o_rise, o_fall, s_rise, s_fall, p_rise, p_fall;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk_pri = ~clk_pri;
    assign clk_sec = ~clk_pri;

    // Opposite, synchronous, both zero at power-up
    ddr2clk_capture u_dut (
        .clk_pri(clk_pri), .clk_sec(clk_sec), .cap_en(cap_en), .ddr_in(ddr_in),
        .clear_in(clear_in), .preset_in(preset_in), .rise_q(o_rise), .fall_q(o_fall)
    );

    // Same mode, asynchronous control
    ddr2clk_capture #(.MODE(ddr2clk_pkg::ALIGN_SAME), .RISE_INIT(1'b1),
                      .FALL_INIT(1'b0), .ASYNC_CTRL(1'b1)) u_dut_same (
        .clk_pri(clk_pri), .clk_sec(clk_sec), .cap_en(cap_en), .ddr_in(ddr_in),
        .clear_in(clear_in), .preset_in(preset_in), .rise_q(s_rise), .fall_q(s_fall)
    );

    // Pipelined mode, synchronous control
    ddr2clk_capture #(.MODE(ddr2clk_pkg::ALIGN_SAME_PIPE), .RISE_INIT(1'b0),
                      .FALL_INIT(1'b1), .ASYNC_CTRL(1'b0)) u_dut_pipe (
        .clk_pri(clk_pri), .clk_sec(clk_sec), .cap_en(cap_en), .ddr_in(ddr_in),
        .clear_in(clear_in), .preset_in(preset_in), .rise_q(p_rise), .fall_q(p_fall)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic h_or, h_of, h_sr, h_sf, h_pr, h_pf;
        // R1: power-up values before any enabled edge
        #1;
        chk("R1 opp rise init", o_rise, 1'b0);
        chk("R1 opp fall init", o_fall, 1'b0);
        chk("R1 same rise init", s_rise, 1'b1);
        chk("R1 same fall init", s_fall, 1'b0);
        chk("R1 pipe rise init", p_rise, 1'b0);
        chk("R1 pipe fall init", p_fall, 1'b1);

        // R6 with enable low (R9: preset still works)
        @(posedge clk_pri); #1 preset_in = 1'b1;
        @(posedge clk_pri); @(posedge clk_pri); #1;
        chk("R6 opp rise", o_rise, 1'b1);
        chk("R6 opp fall", o_fall, 1'b1);
        chk("R6 same rise", s_rise, 1'b1);
        chk("R6 same fall", s_fall, 1'b1);
        chk("R6 pipe rise", p_rise, 1'b1);
        chk("R6 pipe fall", p_fall, 1'b1);
        preset_in = 1'b0;

        // R7 / R8: clear raised between primary edges
        @(posedge clk_pri); #1 clear_in = 1'b1;
        #1;
        chk("R8 same rise immediate", s_rise, 1'b0);
        chk("R8 same fall immediate", s_fall, 1'b0);
        chk("R7 opp rise waits", o_rise, 1'b1);
        chk("R7 pipe rise waits", p_rise, 1'b1);
        @(posedge clk_pri); #1;
        chk("R7 opp rise after edge", o_rise, 1'b0);
        chk("R7 pipe rise after edge", p_rise, 1'b0);

        // R5: clear beats preset
        preset_in = 1'b1;
        @(posedge clk_pri); @(posedge clk_pri); #1;
        chk("R5 opp rise", o_rise, 1'b0);
        chk("R5 opp fall", o_fall, 1'b0);
        chk("R5 same rise", s_rise, 1'b0);
        chk("R5 same fall", s_fall, 1'b0);
        chk("R5 pipe rise", p_rise, 1'b0);
        chk("R5 pipe fall", p_fall, 1'b0);
        clear_in = 1'b0;
        preset_in = 1'b0;

        // Pair table stream: R2, R3, R4
        ddr_in = PAIRS[0][1];
        cap_en = 1'b1;
        for (int k = 0; k < NPAIR; k++) begin
            @(posedge clk_pri);
            #2 ddr_in = PAIRS[k][0];
            #4;
            if (k + 1 < NPAIR) ddr_in = PAIRS[k + 1][1];
            else               ddr_in = 1'b0;
            #1;
            chk("R2 opp rise", o_rise, PAIRS[k][1]);
            chk("R2 opp fall", o_fall, PAIRS[k][0]);
            chk("R3 same rise", s_rise, PAIRS[k][1]);
            if (k > 0) begin
                chk("R3 same fall", s_fall, PAIRS[k - 1][0]);
                chk("R4 pipe rise", p_rise, PAIRS[k - 1][1]);
                chk("R4 pipe fall", p_fall, PAIRS[k - 1][0]);
            end
        end

        // R9: enable low ignores toggling input
        h_or = o_rise; h_of = o_fall; h_sr = s_rise;
        h_sf = s_fall; h_pr = p_rise; h_pf = p_fall;
        cap_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk_pri);
            #2 ddr_in = ~ddr_in;
        end
        #1;
        chk("R9 opp rise hold", o_rise, h_or);
        chk("R9 opp fall hold", o_fall, h_of);
        chk("R9 same rise hold", s_rise, h_sr);
        chk("R9 same fall hold", s_fall, h_sf);
        chk("R9 pipe rise hold", p_rise, h_pr);
        chk("R9 pipe fall hold", p_fall, h_pf);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule